// File: doc/BRIEF.md
# Serial ADC Sampling Sequencer

This block drives a bank of serial analog-to-digital converters that share one serial clock and one chip select, and turns each round of conversions into gain-corrected sample words. From the system clock it divides down a slow serial clock. It lowers chip select for the conversion and shift-out window and takes one data bit per channel on each serial-clock falling edge, most significant bit first. It then walks through the channels one by one. In each step it scales one channel's raw sample by that channel's programmable fixed-point gain and clips the result to the sample width.

A frame is a fixed sequence of serial-clock periods: one idle step, one conversion wait, one skipped null bit, SAMPLE_W data bits, CHANNELS calibration steps and STALL_TICKS stall steps. This gives a sample period of (3 + SAMPLE_W + CHANNELS + STALL_TICKS) serial periods. With the defaults (50 MHz system clock, 600 ns serial clock, 10 bits, 12 channels, 820 stall steps) that is 845 × 600 ns, close to 2 kHz. The sequencer runs while `start` is high. When `start` drops, the frame in progress runs to its end and the block then waits in its idle step.

The calibrated words leave as a valid-only stream. `cal_valid` pulses for one system clock when all words of a frame are in place. There is no ready input: the block samples at a fixed rate and cannot be held back. A consumer has to take the words before the next frame's calibration starts, which is signalled by `conv_done` rising.

Top module: `adc_sample_seq`

## Requirements
- R1: While `rst_n` is low, `adc_sck` is 0, `adc_cs_n` is 1, `conv_done` and `cal_valid` are 0 and every calibrated word is 0.
- R2: When the sequencer is idle and `start` is low, `adc_sck` stays low and `adc_cs_n` stays high.
- R3: While running, `adc_sck` has a period of 2·SCK_HALF_CYC system clocks, and each frame step lasts exactly one such period, ending on a falling edge.
- R4: `adc_cs_n` falls at the falling edge that leaves the idle step with `start` high, and stays low for exactly SAMPLE_W + 2 serial periods (conversion wait, null bit, data bits).
- R5: Counting falling edges of `adc_sck` after `adc_cs_n` falls, edges 1 and 2 take no data, and edges 3 to SAMPLE_W+2 take the sample from MSB to LSB. Each channel i reads `adc_miso[i]`.
- R6: `conv_done` rises on the same clock as `adc_cs_n` rises, stays high for CHANNELS + STALL_TICKS serial periods, and while running stays low for SAMPLE_W + 3 serial periods.
- R7: The word of channel i, at `cal_words[i*SAMPLE_W +: SAMPLE_W]`, equals floor(raw_i · gain_i / 2^GAIN_FRAC), with gain_i taken unsigned from `gain_flat[i*GAIN_W +: GAIN_W]`.
- R8: A scaled result above 2^SAMPLE_W − 1 is replaced by 2^SAMPLE_W − 1.
- R9: `cal_valid` is a single-cycle pulse that comes CHANNELS serial periods after `conv_done` rises, once per frame.
- R10: While `start` stays high, successive `cal_valid` pulses are (3 + SAMPLE_W + CHANNELS + STALL_TICKS)·2·SCK_HALF_CYC system clocks apart.
- R11: If `start` falls during a frame, that frame still delivers its words and `cal_valid`, after which no new frame starts, `adc_sck` stays low and `conv_done` is 0.
- R12: Calibrated words change only while `conv_done` is high and otherwise hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run enable; sampled at the end of the idle step |
| adc_miso | input | CHANNELS | One serial data line per converter |
| gain_flat | input | CHANNELS·GAIN_W | Unsigned fixed-point gains, channel i in field i |
| adc_sck | output | 1 | Serial clock shared by all converters |
| adc_cs_n | output | 1 | Active-low chip select shared by all converters |
| conv_done | output | 1 | High from LSB capture until the frame returns to idle |
| cal_valid | output | 1 | One-cycle pulse: all calibrated words of the frame are valid |
| cal_words | output | CHANNELS·SAMPLE_W | Calibrated words, channel i in field i |

## Verification
The hardest case to reach from the ports is `start` dropping while a frame is in flight, after data capture but before calibration ends. The stimulus waits for `conv_done` to rise, releases `start` at once, and then checks that the words still arrive and that the serial clock goes quiet. Bit alignment is also subtle. A behavioural converter model counts serial-clock rising edges from the fall of chip select and drives ones on the wait and null positions. A capture that is off by one step, or taken in the wrong bit order, then produces wrong words. Gain values of zero, one half, unity and near four, combined with full-scale samples, cover both the clipping and the truncation paths.

// File: rtl/adcseq_pkg.sv
`timescale 1ns/1ps
package adcseq_pkg;

  // Frame phases; SHIFT and CAL repeat under an index counter.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CONV  = 3'd1,
    PH_NULL  = 3'd2,
    PH_SHIFT = 3'd3,
    PH_CAL   = 3'd4,
    PH_STALL = 3'd5
  } phase_e;

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adcseq_sck_gen.sv
`timescale 1ns/1ps
module adcseq_sck_gen import adcseq_pkg::*; #(
  parameter int SCK_HALF_CYC = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic fall_tick
);
  localparam int CW = cnt_width(SCK_HALF_CYC);

  logic [CW-1:0] div_q;
  logic          sck_q;
  logic          active;
  logic          wrap;

  // Keep going while asked to, or until a high phase has completed.
  assign active = run || sck_q;
  assign wrap   = (div_q == CW'(SCK_HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      sck_q <= 1'b0;
    end else if (active) begin
      if (wrap) begin
        div_q <= '0;
        sck_q <= ~sck_q;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end else begin
      div_q <= '0;
    end
  end

  assign sck       = sck_q;
  assign fall_tick = active && wrap && sck_q;

endmodule

// File: rtl/adcseq_fsm.sv
`timescale 1ns/1ps
module adcseq_fsm import adcseq_pkg::*; #(
  parameter int SAMPLE_W    = 10,
  parameter int CHANNELS    = 12,
  parameter int STALL_TICKS = 820,
  parameter int IDX_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  output logic             run,
  output logic             cs_n,
  output logic             shift_en,
  output logic             cal_en,
  output logic [IDX_W-1:0] cal_idx,
  output logic             conv_done,
  output logic             frame_valid
);
  localparam int SCW = cnt_width(STALL_TICKS);

  phase_e           ph_q, ph_nx;
  logic [IDX_W-1:0] idx_q, idx_nx;
  logic [SCW-1:0]   stall_q, stall_nx;
  logic             last_bit, last_ch, last_stall;
  logic             cs_active_nx;

  assign last_bit   = (idx_q == IDX_W'(SAMPLE_W - 1));
  assign last_ch    = (idx_q == IDX_W'(CHANNELS - 1));
  assign last_stall = (stall_q == SCW'(STALL_TICKS - 1));

  always_comb begin
    ph_nx    = ph_q;
    idx_nx   = idx_q;
    stall_nx = stall_q;
    unique case (ph_q)
      PH_IDLE: begin
        stall_nx = '0;
        idx_nx   = '0;
        if (start) ph_nx = PH_CONV;
      end
      PH_CONV: ph_nx = PH_NULL;
      PH_NULL: begin
        ph_nx  = PH_SHIFT;
        idx_nx = '0;
      end
      PH_SHIFT: begin
        if (last_bit) begin
          ph_nx  = PH_CAL;
          idx_nx = '0;
        end else begin
          idx_nx = idx_q + 1'b1;
        end
      end
      PH_CAL: begin
        if (last_ch) ph_nx = PH_STALL;
        else         idx_nx = idx_q + 1'b1;
      end
      PH_STALL: begin
        if (last_stall) ph_nx = PH_IDLE;
        else            stall_nx = stall_q + 1'b1;
      end
      default: ph_nx = PH_IDLE;
    endcase
  end

  assign cs_active_nx = (ph_nx == PH_CONV) || (ph_nx == PH_NULL) || (ph_nx == PH_SHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q        <= PH_IDLE;
      idx_q       <= '0;
      stall_q     <= '0;
      cs_n        <= 1'b1;
      conv_done   <= 1'b0;
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (tick) begin
        ph_q    <= ph_nx;
        idx_q   <= idx_nx;
        stall_q <= stall_nx;
        cs_n    <= !cs_active_nx;
        if ((ph_q == PH_SHIFT) && last_bit)
          conv_done <= 1'b1;
        else if ((ph_q == PH_STALL) && last_stall)
          conv_done <= 1'b0;
        frame_valid <= (ph_q == PH_CAL) && last_ch;
      end
    end
  end

  assign run      = start || (ph_q != PH_IDLE);
  assign shift_en = tick && (ph_q == PH_SHIFT);
  assign cal_en   = tick && (ph_q == PH_CAL);
  assign cal_idx  = idx_q;

endmodule

// File: rtl/adcseq_capture.sv
`timescale 1ns/1ps
module adcseq_capture #(
  parameter int CHANNELS = 12,
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic [CHANNELS-1:0] miso,
  output logic [SAMPLE_W-1:0] raw [CHANNELS]
);
  // One MSB-first shift register per converter line.
  for (genvar c = 0; c < CHANNELS; c++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)        raw[c] <= '0;
      else if (shift_en) raw[c] <= {raw[c][SAMPLE_W-2:0], miso[c]};
    end
  end

endmodule

// File: rtl/adcseq_calib.sv
`timescale 1ns/1ps
module adcseq_calib #(
  parameter int CHANNELS  = 12,
  parameter int SAMPLE_W  = 10,
  parameter int GAIN_W    = 10,
  parameter int GAIN_FRAC = 8,
  parameter int IDX_W     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cal_en,
  input  logic [IDX_W-1:0]    cal_idx,
  input  logic [SAMPLE_W-1:0] raw  [CHANNELS],
  input  logic [GAIN_W-1:0]   gain [CHANNELS],
  output logic [SAMPLE_W-1:0] word [CHANNELS]
);
  localparam int PW = SAMPLE_W + GAIN_W;
  localparam int QW = PW - GAIN_FRAC;   // must exceed SAMPLE_W

  logic [SAMPLE_W-1:0] sel_raw;
  logic [GAIN_W-1:0]   sel_gain;
  logic [PW-1:0]       prod;
  logic [QW-1:0]       scaled;
  logic [SAMPLE_W-1:0] clipped;

  // One shared multiplier, steered by the channel index.
  always_comb begin
    sel_raw  = '0;
    sel_gain = '0;
    for (int i = 0; i < CHANNELS; i++) begin
      if (cal_idx == IDX_W'(i)) begin
        sel_raw  = raw[i];
        sel_gain = gain[i];
      end
    end
  end

  assign prod    = PW'(sel_raw) * PW'(sel_gain);
  assign scaled  = prod[PW-1:GAIN_FRAC];
  assign clipped = (|scaled[QW-1:SAMPLE_W]) ? {SAMPLE_W{1'b1}} : scaled[SAMPLE_W-1:0];

  for (genvar c = 0; c < CHANNELS; c++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        word[c] <= '0;
      else if (cal_en && (cal_idx == IDX_W'(c)))
        word[c] <= clipped;
    end
  end

endmodule

// File: rtl/adc_sample_seq.sv
`timescale 1ns/1ps
module adc_sample_seq import adcseq_pkg::*; #(
  parameter int CHANNELS     = 12,
  parameter int SAMPLE_W     = 10,
  parameter int GAIN_W       = 10,
  parameter int GAIN_FRAC    = 8,
  parameter int SCK_HALF_CYC = 15,
  parameter int STALL_TICKS  = 820
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [CHANNELS-1:0]          adc_miso,
  input  logic [CHANNELS*GAIN_W-1:0]   gain_flat,
  output logic                         adc_sck,
  output logic                         adc_cs_n,
  output logic                         conv_done,
  output logic                         cal_valid,
  output logic [CHANNELS*SAMPLE_W-1:0] cal_words
);
  localparam int IDX_W = cnt_width(max2(SAMPLE_W, CHANNELS));

  logic             run, tick, shift_en, cal_en;
  logic [IDX_W-1:0] cal_idx;
  logic [SAMPLE_W-1:0] raw_a  [CHANNELS];
  logic [GAIN_W-1:0]   gain_a [CHANNELS];
  logic [SAMPLE_W-1:0] word_a [CHANNELS];

  for (genvar c = 0; c < CHANNELS; c++) begin : g_io
    assign gain_a[c] = gain_flat[c*GAIN_W +: GAIN_W];
    assign cal_words[c*SAMPLE_W +: SAMPLE_W] = word_a[c];
  end

  adcseq_sck_gen #(
    .SCK_HALF_CYC(SCK_HALF_CYC)
  ) u_sck (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .sck       (adc_sck),
    .fall_tick (tick)
  );

  adcseq_fsm #(
    .SAMPLE_W    (SAMPLE_W),
    .CHANNELS    (CHANNELS),
    .STALL_TICKS (STALL_TICKS),
    .IDX_W       (IDX_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .tick        (tick),
    .run         (run),
    .cs_n        (adc_cs_n),
    .shift_en    (shift_en),
    .cal_en      (cal_en),
    .cal_idx     (cal_idx),
    .conv_done   (conv_done),
    .frame_valid (cal_valid)
  );

  adcseq_capture #(
    .CHANNELS (CHANNELS),
    .SAMPLE_W (SAMPLE_W)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .miso     (adc_miso),
    .raw      (raw_a)
  );

  adcseq_calib #(
    .CHANNELS  (CHANNELS),
    .SAMPLE_W  (SAMPLE_W),
    .GAIN_W    (GAIN_W),
    .GAIN_FRAC (GAIN_FRAC),
    .IDX_W     (IDX_W)
  ) u_cal (
    .clk     (clk),
    .rst_n   (rst_n),
    .cal_en  (cal_en),
    .cal_idx (cal_idx),
    .raw     (raw_a),
    .gain    (gain_a),
    .word    (word_a)
  );

endmodule

// File: rtl/adcseq_chk.sv
`timescale 1ns/1ps
module adcseq_chk #(
  parameter int WORDS_W = 120
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               adc_sck,
  input logic               adc_cs_n,
  input logic               conv_done,
  input logic               cal_valid,
  input logic [WORDS_W-1:0] cal_words
);

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_valid |=> !cal_valid);  // R9

  AST_VALID_INSIDE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_valid |-> conv_done);  // R6

  AST_DONE_WITH_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_done) |-> $rose(adc_cs_n));  // R6

  AST_FRAME_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> $past(start));  // R11

  AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cal_words) |-> conv_done);  // R12

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && adc_cs_n && !conv_done && !adc_sck) |=> !adc_sck);  // R2

endmodule

bind adc_sample_seq adcseq_chk #(
  .WORDS_W (CHANNELS*SAMPLE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .adc_sck   (adc_sck),
  .adc_cs_n  (adc_cs_n),
  .conv_done (conv_done),
  .cal_valid (cal_valid),
  .cal_words (cal_words)
);

// File: tb/sim_adc_sample_seq.sv
`timescale 1ns/1ps
module sim_adc_sample_seq;
  localparam int CH    = 12;
  localparam int SW    = 10;
  localparam int GW    = 10;
  localparam int GF    = 8;
  localparam int HALF  = 2;
  localparam int STALL = 6;
  localparam int T     = 2 * HALF;
  localparam int MAXW  = (1 << SW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CH-1:0]    adc_miso = '1;
  logic [CH*GW-1:0] gain_flat = '0;
  wire              adc_sck, adc_cs_n, conv_done, cal_valid;
  wire  [CH*SW-1:0] cal_words;

  always #2.5 clk = ~clk;

  adc_sample_seq #(
    .CHANNELS(CH), .SAMPLE_W(SW), .GAIN_W(GW), .GAIN_FRAC(GF),
    .SCK_HALF_CYC(HALF), .STALL_TICKS(STALL)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .adc_miso(adc_miso),
    .gain_flat(gain_flat), .adc_sck(adc_sck), .adc_cs_n(adc_cs_n),
    .conv_done(conv_done), .cal_valid(cal_valid), .cal_words(cal_words)
  );

  int tests = 0;
  int fails = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  logic [SW-1:0] smp [CH];
  int rc = 0;
  initial begin : adc_model
    forever begin
      @(posedge adc_sck or posedge adc_cs_n);
      if (adc_cs_n) rc = 0;
      else          rc++;
      for (int c = 0; c < CH; c++)
        adc_miso[c] = (!adc_cs_n && rc >= 3 && rc < 3 + SW) ? smp[c][SW-1-(rc-3)] : 1'b1;
    end
  end

  // ---------------- scoreboard ----------------
  logic [CH*SW-1:0] exp_q[$];
  string            tag_q[$];
  logic [CH*SW-1:0] ew;
  string            tg;

  function automatic int expw(input int s, input int g);
    int p;
    p = (s * g) / (1 << GF);
    return (p > MAXW) ? MAXW : p;
  endfunction

  task automatic load_frame(input int kind, input string tag);
    logic [CH*SW-1:0] e;
    int s, g;
    e = '0;
    for (int c = 0; c < CH; c++) begin
      case (kind)
        0: begin s = 40 + c * 85; g = 256; end
        1: begin
          s = 1023 - c * 37;
          g = (c == 0) ? 0 : (c == 1) ? 128 : (c == 2) ? 1023 : 300 + c * 50;
        end
        2: begin
          s = (c % 2 == 1) ? 1 : 512;
          if (c == 4) s = 1023;
          if (c == 6) s = 'h155;
          if (c == 8) s = 'h2AA;
          g = 256;
        end
        3: begin s = (c * 211 + 17) % 1024; g = 200 + c * 70; end
        4: begin s = c * 60 + 5; g = 300; end
        default: begin s = 1000 - c * 50; g = 256 + c * 30; end
      endcase
      smp[c] = SW'(s);
      gain_flat[c*GW +: GW] = GW'(g);
      e[c*SW +: SW] = SW'(expw(s, g));
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst_n && cal_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "cal_valid with nothing expected", 1, 0);
        end else begin
          ew = exp_q.pop_front();
          tg = tag_q.pop_front();
          for (int c = 0; c < CH; c++)
            check(cal_words[c*SW +: SW] == ew[c*SW +: SW], tg, $sformatf("word ch%0d", c),
                  cal_words[c*SW +: SW], ew[c*SW +: SW]);
          repeat (60) @(negedge clk);
          for (int c = 0; c < CH; c++)
            check(cal_words[c*SW +: SW] == ew[c*SW +: SW], "R12", $sformatf("held word ch%0d", c),
                  cal_words[c*SW +: SW], ew[c*SW +: SW]);
        end
      end
    end
  end

  // ---------------- timing monitor ----------------
  int  cyc = 0;
  int  cs_fall = -1, done_rise = -1, done_fall = -1, last_cal = -1, last_rise = -1;
  logic p_sck = 1'b0, p_cs = 1'b1, p_done = 1'b0, p_val = 1'b0;
  bit  cont_cal = 1'b0, cont_low = 1'b0, last_rise_cs_low = 1'b0;

  initial begin : timing_mon
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (!start) begin
          cont_cal = 1'b0;
          cont_low = 1'b0;
        end
        if (!p_sck && adc_sck) begin
          if (last_rise >= 0 && last_rise_cs_low && !adc_cs_n)
            check(cyc - last_rise == T, "R3", "sck period", cyc - last_rise, T);
          last_rise = cyc;
          last_rise_cs_low = !adc_cs_n;
        end
        if (p_cs && !adc_cs_n) cs_fall = cyc;
        if (!p_cs && adc_cs_n && cs_fall >= 0) begin
          check(cyc - cs_fall == (SW + 2) * T, "R4", "chip select low time",
                cyc - cs_fall, (SW + 2) * T);
          check(conv_done && !p_done, "R6", "done rises with cs release", conv_done, 1);
        end
        if (!p_done && conv_done) begin
          if (done_fall >= 0 && cont_low)
            check(cyc - done_fall == (SW + 3) * T, "R6", "done low time",
                  cyc - done_fall, (SW + 3) * T);
          done_rise = cyc;
        end
        if (p_done && !conv_done) begin
          if (done_rise >= 0)
            check(cyc - done_rise == (CH + STALL) * T, "R6", "done high time",
                  cyc - done_rise, (CH + STALL) * T);
          done_fall = cyc;
          cont_low = 1'b1;
        end
        if (cal_valid && !p_val) begin
          check(cyc - done_rise == CH * T, "R9", "valid after done", cyc - done_rise, CH * T);
          if (last_cal >= 0 && cont_cal)
            check(cyc - last_cal == (3 + SW + CH + STALL) * T, "R10", "frame spacing",
                  cyc - last_cal, (3 + SW + CH + STALL) * T);
          last_cal = cyc;
          cont_cal = 1'b1;
        end
        if (p_val)
          check(!cal_valid, "R9", "valid width", cal_valid, 0);
      end
      p_sck  = adc_sck;
      p_cs   = adc_cs_n;
      p_done = conv_done;
      p_val  = cal_valid;
    end
  end

  // ---------------- watchdog ----------------
  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic wait_cal();
    do @(negedge clk); while (!cal_valid);
  endtask

  // ---------------- driver ----------------
  initial begin : driver
    int hi_cnt, cs_cnt;
    repeat (4) @(negedge clk);
    check(adc_sck == 1'b0,   "R1", "sck in reset", adc_sck, 0);
    check(adc_cs_n == 1'b1,  "R1", "cs_n in reset", adc_cs_n, 1);
    check(conv_done == 1'b0, "R1", "done in reset", conv_done, 0);
    check(cal_valid == 1'b0, "R1", "valid in reset", cal_valid, 0);
    check(cal_words == '0,   "R1", "words in reset", cal_words[SW-1:0], 0);
    rst_n = 1'b1;

    hi_cnt = 0; cs_cnt = 0;
    repeat (40) begin
      @(negedge clk);
      if (adc_sck) hi_cnt++;
      if (!adc_cs_n) cs_cnt++;
    end
    check(hi_cnt == 0 && cs_cnt == 0, "R2", "idle without start", hi_cnt + cs_cnt, 0);

    load_frame(0, "R7");
    start = 1'b1;
    wait_cal();
    load_frame(1, "R8");
    wait_cal();
    load_frame(2, "R5");
    wait_cal();
    load_frame(3, "R7");
    wait_cal();

    // stop in the middle of a frame, just after capture
    load_frame(4, "R11");
    do @(negedge clk); while (conv_done);
    do @(negedge clk); while (!conv_done);
    start = 1'b0;
    wait_cal();
    repeat (40) @(negedge clk);
    hi_cnt = 0; cs_cnt = 0;
    repeat (100) begin
      @(negedge clk);
      if (adc_sck) hi_cnt++;
      if (!adc_cs_n) cs_cnt++;
    end
    check(hi_cnt == 0, "R11", "sck quiet after stop", hi_cnt, 0);
    check(cs_cnt == 0, "R11", "no new frame after stop", cs_cnt, 0);
    check(conv_done == 1'b0, "R11", "done low after stop", conv_done, 0);

    load_frame(5, "R7");
    start = 1'b1;
    wait_cal();
    repeat (80) @(negedge clk);
    check(exp_q.size() == 0, "R9", "frames left unreported", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule